// File: doc/BRIEF.md
# AES-128 Key Schedule with Alternate-Field Round Constants

This block turns a 128-bit seed key into the eleven 128-bit round keys of a ten-round AES-style cipher. It produces one 32-bit schedule word per clock and keeps all 44 words in a register array, so the cipher datapath can read any round key by index. It serves both directions: encryption reads indices 0 to 10 in rising order, and decryption reads the same stored keys from 10 down to 0.

The round constants come from repeated doubling in GF(2^8). The reduction polynomial is x^8+x^4+x^3+x^2+1 (0x11D), not the usual 0x11B. The substitution table is not inside the block. Once per round, the block puts the rotated previous word on a lookup port. An outside table must return the four substituted bytes combinationally, in the same cycle.

A key is handed over with a valid/ready pair. The seed is taken in the cycle when `load_valid` and `load_ready` are both high. `load_ready` is low for the whole expansion. A source holding `load_valid` high is stalled until the expansion ends, and no key is lost or taken twice. `key_rdy` is a plain status level.

Top module: `rcon_key_expander`

## Requirements
- R1: After reset, `key_rdy` is 0, `load_ready` is 1 and every round-key index reads as all zeros.
- R2: After a key is accepted, round key 0 equals the seed key. Word w0 is `seed_key[127:96]` and w3 is `seed_key[31:0]`.
- R3: For each word index i from 4 to 43 with i mod 4 not 0, w[i] = w[i-4] XOR w[i-1].
- R4: For each i mod 4 = 0 with i from 4 to 40, w[i] = w[i-4] XOR S(rot(w[i-1])) XOR {RC(i/4), 24'h0}. Here rot moves bits [31:24] to bits [7:0], and S substitutes each byte through the lookup port (`sub_query` out, `sub_reply` in, byte lanes matching).
- R5: RC(1) = 0x01 and RC(j) = 2·RC(j-1) reduced by 0x11D, which gives 01,02,04,08,10,20,40,80,1D,3A. In particular RC(9) = 0x1D and RC(10) = 0x3A.
- R6: `key_rdy` rises exactly 40 clock edges after the accepting edge and stays 0 until then.
- R7: `load_ready` is 0 from the accepting edge until `key_rdy` rises. A load held valid over that time is accepted on the first edge after `key_rdy` rises, and its seed is the one that gets expanded.
- R8: An accepted load clears `key_rdy` on the accepting edge.
- R9: `rk_idx` = k (0..10) returns {w[4k], w[4k+1], w[4k+2], w[4k+3]}, with w[4k] in bits [127:96]. Indices 11 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Seed key offered |
| load_ready | output | 1 | Block can take a seed this cycle |
| seed_key | input | 128 | Seed key, w0 in the top 32 bits |
| sub_query | output | 32 | Rotated previous word sent to the substitution table |
| sub_reply | input | 32 | Byte-wise substituted `sub_query`, same cycle |
| rk_idx | input | 4 | Round-key index to read |
| rk_data | output | 128 | Round key at `rk_idx` (combinational) |
| key_rdy | output | 1 | All 44 words are valid |

## Verification
Two events can fall in the same cycle: the last schedule word being written, and a new load that was held pending behind it. The bench keeps `load_valid` high with a second seed for the whole first expansion. It checks `load_ready` every cycle, and it checks that the handover happens on the edge right after `key_rdy` rises. That edge must drop `key_rdy` again, and the second schedule must match the second seed in every word. The round-constant wrap is judged from the observed words alone, by recovering RC(9) and RC(10) from w[32], w[35], w[36] and from w[36], w[39], w[40].

// File: rtl/rke_pkg.sv
package rke_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [7:0] gf_double(input logic [7:0] v, input logic [7:0] low_poly);
    gf_double = v[7] ? ({v[6:0], 1'b0} ^ low_poly) : {v[6:0], 1'b0};
  endfunction

  function automatic word_t rot_word(input word_t v);
    rot_word = {v[23:0], v[31:24]};
  endfunction
endpackage

// File: rtl/rke_rcon.sv
module rke_rcon #(
  parameter logic [7:0] LOW_POLY = 8'h1D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       advance,
  output logic [7:0] rc
);
  import rke_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rc <= 8'h01;
    else if (restart) rc <= 8'h01;
    else if (advance) rc <= gf_double(rc, LOW_POLY);
  end

  // R5: the constant is never zero in a field
  a_r5_rc_nonzero: assert property (@(posedge clk) disable iff (!rst_n) rc != 8'h00);
  // R5: wrap past the top bit uses the alternate reduction
  a_r5_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && rc == 8'h80) |=> rc == 8'h1D);
  a_r5_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && rc == 8'h1D) |=> rc == 8'h3A);
endmodule

// File: rtl/rke_word_path.sv
module rke_word_path #(
  parameter int unsigned NK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NK*32-1:0] seed,
  input  logic             step,
  input  logic             round_word,
  input  logic [7:0]       rc,
  output logic [31:0]      sub_query,
  input  logic [31:0]      sub_reply,
  output logic [31:0]      next_word
);
  import rke_pkg::*;

  word_t win [NK];
  word_t temp;

  assign sub_query = rot_word(win[NK-1]);
  assign temp      = round_word ? (sub_reply ^ {rc, 24'h0}) : win[NK-1];
  assign next_word = win[0] ^ temp;

  generate
    for (genvar g = 0; g < NK; g++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    win[g] <= '0;
        else if (load) win[g] <= seed[(NK-1-g)*32 +: 32];
        else if (step) begin
          if (g == NK-1) win[g] <= next_word;
          else           win[g] <= win[g+1];
        end
      end
    end
  endgenerate

  // R3: the window slides by one word per step
  a_r3_window_slides: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> win[0] == $past(win[1]));
endmodule

// File: rtl/rke_store.sv
module rke_store #(
  parameter int unsigned NWORDS = 44,
  parameter int unsigned NK     = 4,
  parameter int unsigned PTR_W  = 6,
  parameter int unsigned IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NK*32-1:0] seed,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [31:0]      wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [NK*32-1:0] rd_key
);
  localparam int unsigned NKEYS = NWORDS / NK;

  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < NK; i++) mem[i] <= seed[(NK-1-i)*32 +: 32];
    end else if (wr_en && int'(wr_ptr) < NWORDS) begin
      mem[wr_ptr] <= wr_word;
    end
  end

  always_comb begin
    rd_key = '0;
    if (int'(rd_idx) < NKEYS) begin
      for (int j = 0; j < NK; j++)
        rd_key[(NK-1-j)*32 +: 32] = mem[int'(rd_idx)*NK + j];
    end
  end

  // R2: the seed lands in the first words
  a_r2_seed_stored: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mem[0] == $past(seed[NK*32-1 -: 32])));
endmodule

// File: rtl/rcon_key_expander.sv
module rcon_key_expander #(
  parameter int unsigned ROUNDS   = 10,
  parameter logic [7:0]  LOW_POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [127:0] seed_key,
  output logic [31:0]  sub_query,
  input  logic [31:0]  sub_reply,
  input  logic [3:0]   rk_idx,
  output logic [127:0] rk_data,
  output logic         key_rdy
);
  localparam int unsigned NK     = 4;
  localparam int unsigned NWORDS = NK * (ROUNDS + 1);
  localparam int unsigned PTR_W  = $clog2(NWORDS + 1);
  localparam int unsigned IDX_W  = 4;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWORDS - 1);

  logic             busy;
  logic [PTR_W-1:0] ptr;
  logic             load_fire;
  logic             round_word;
  logic [7:0]       rc;
  logic [31:0]      next_word;

  assign load_ready = !busy;
  assign load_fire  = load_valid && load_ready;
  assign round_word = (ptr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ptr     <= '0;
      key_rdy <= 1'b0;
    end else if (load_fire) begin
      busy    <= 1'b1;
      ptr     <= PTR_W'(NK);
      key_rdy <= 1'b0;
    end else if (busy) begin
      ptr <= ptr + 1'b1;
      if (ptr == LAST) begin
        busy    <= 1'b0;
        key_rdy <= 1'b1;
      end
    end
  end

  rke_rcon #(.LOW_POLY(LOW_POLY)) rcon_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_fire),
    .advance (busy && round_word),
    .rc      (rc)
  );

  rke_word_path #(.NK(NK)) path_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_fire),
    .seed       (seed_key),
    .step       (busy),
    .round_word (round_word),
    .rc         (rc),
    .sub_query  (sub_query),
    .sub_reply  (sub_reply),
    .next_word  (next_word)
  );

  rke_store #(.NWORDS(NWORDS), .NK(NK), .PTR_W(PTR_W), .IDX_W(IDX_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_fire),
    .seed    (seed_key),
    .wr_en   (busy),
    .wr_ptr  (ptr),
    .wr_word (next_word),
    .rd_idx  (rk_idx),
    .rd_key  (rk_data)
  );

  // R6: ready rises only right after the last word is written
  a_r6_rdy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_rdy) |-> $past(ptr) == LAST);
  a_r6_not_rdy_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !key_rdy);
  // R8: an accepted load drops the ready flag
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !key_rdy);
  // R7: nothing is accepted while words are still being produced
  a_r7_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ptr != LAST) |=> !load_ready);
endmodule

// File: tb/rcon_key_expander_tb_top.sv
module rcon_key_expander_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_valid = 1'b0;
  logic         load_ready;
  logic [127:0] seed_key = '0;
  logic [31:0]  sub_query;
  logic [31:0]  sub_reply;
  logic [3:0]   rk_idx = '0;
  logic [127:0] rk_data;
  logic         key_rdy;

  int checks = 0;
  int fails  = 0;
  logic [31:0] ew [44];

  always #5 clk = ~clk;

  function automatic logic [7:0] sb(input logic [7:0] x);
    sb = 8'((x * 8'd7) + 8'h63);
  endfunction
  function automatic logic [31:0] subw(input logic [31:0] v);
    subw = {sb(v[31:24]), sb(v[23:16]), sb(v[15:8]), sb(v[7:0])};
  endfunction

  assign sub_reply = subw(sub_query);

  rcon_key_expander dut_i (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .seed_key(seed_key), .sub_query(sub_query), .sub_reply(sub_reply),
    .rk_idx(rk_idx), .rk_data(rk_data), .key_rdy(key_rdy)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [127:0] k);
    logic [7:0] rc;
    logic [31:0] t;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) ew[i] = k[(3-i)*32 +: 32];
    for (int i = 4; i < 44; i++) begin
      if (i % 4 == 0) begin
        t = subw({ew[i-1][23:0], ew[i-1][31:24]}) ^ {rc, 24'h0};
        rc = rc[7] ? ({rc[6:0], 1'b0} ^ 8'h1D) : {rc[6:0], 1'b0};
      end else t = ew[i-1];
      ew[i] = ew[i-4] ^ t;
    end
  endtask

  task automatic check_all(input string what);
    for (int k = 0; k < 16; k++) begin
      logic [127:0] e;
      rk_idx = 4'(k);
      #1;
      e = (k <= 10) ? {ew[4*k], ew[4*k+1], ew[4*k+2], ew[4*k+3]} : '0;
      if (k == 0) check(rk_data == e, {"R2 ", what}, rk_data, e);
      else if (k <= 10) check(rk_data == e, {"R3/R4 ", what}, rk_data, e);
      else check(rk_data == e, {"R9 ", what}, rk_data, e);
    end
  endtask

  task automatic check_rc_tail();
    logic [31:0] w32, w35, w36, w39, w40, r;
    rk_idx = 4'd8; #1; w32 = rk_data[127:96]; w35 = rk_data[31:0];
    rk_idx = 4'd9; #1; w36 = rk_data[127:96]; w39 = rk_data[31:0];
    rk_idx = 4'd10; #1; w40 = rk_data[127:96];
    r = w36 ^ w32 ^ subw({w35[23:0], w35[31:24]});
    check(r == 32'h1D000000, "R5 RC(9)", 128'(r), 128'h1D000000);
    r = w40 ^ w36 ^ subw({w39[23:0], w39[31:24]});
    check(r == 32'h3A000000, "R5 RC(10)", 128'(r), 128'h3A000000);
  endtask

  // accept a key at the next edge, count edges until key_rdy
  task automatic run_key(input logic [127:0] k, input string what);
    int n;
    @(negedge clk);
    seed_key = k; load_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    check(key_rdy == 1'b0, "R8 cleared on load", 128'(key_rdy), 128'd0);
    n = 0;
    while (!key_rdy && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!key_rdy && load_ready) check(1'b0, "R7 ready during expansion", 128'(load_ready), 128'd0);
    end
    check(n == 40, "R6 latency", 128'(n), 128'd40);
    model(k);
    check_all(what);
  endtask

  initial begin
    #50000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [127:0] ka, kb;
    int n;
    repeat (3) @(negedge clk);
    check(key_rdy == 1'b0, "R1 key_rdy reset", 128'(key_rdy), 128'd0);
    check(load_ready == 1'b1, "R1 load_ready reset", 128'(load_ready), 128'd1);
    rk_idx = 4'd5; #1;
    check(rk_data == '0, "R1 store reset", rk_data, 128'd0);
    rst_n = 1'b1;

    run_key('0, "zero key");
    check_rc_tail();
    run_key({128{1'b1}}, "ones key");
    check_rc_tail();
    run_key(128'h000102030405060708090a0b0c0d0e0f, "ramp key");
    run_key(128'h7fc023a814b5d69e2b7e151628aed2a6, "mixed key");
    check_rc_tail();

    // held load behind a running expansion
    ka = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    kb = 128'hdeadbeefcafef00d0123456789abcdef;
    @(negedge clk);
    seed_key = ka; load_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    seed_key = kb;
    n = 0;
    while (!key_rdy && n < 100) begin
      check(load_ready == 1'b0, "R7 stalled while busy", 128'(load_ready), 128'd0);
      @(posedge clk); n++;
      @(negedge clk);
    end
    check(n == 40, "R6 latency held", 128'(n), 128'd40);
    check(load_ready == 1'b1, "R7 ready after done", 128'(load_ready), 128'd1);
    model(ka);
    rk_idx = 4'd10; #1;
    check(rk_data == {ew[40], ew[41], ew[42], ew[43]}, "R7 first key complete",
          rk_data, {ew[40], ew[41], ew[42], ew[43]});
    @(posedge clk);
    @(negedge clk);
    load_valid = 1'b0;
    check(key_rdy == 1'b0, "R8 held load accepted next edge", 128'(key_rdy), 128'd0);
    n = 0;
    while (!key_rdy && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    check(n == 40, "R6 latency second", 128'(n), 128'd40);
    model(kb);
    check_all("R7 held second key");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule